// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter with a 6-bit control register. It counts either an internal tick, which is one pulse every four system clocks, or rising edges on an external clock input. A power-of-two prescaler (divide by 1, 2, 4 or 8) sits between the selected source and the counter. External edges can pass through a two-flop synchronizer, or reach the edge detector directly with only a single sampling flop.

Software reads and writes the low byte, the high byte and the control register through a small byte-wide register port. The counter wraps from FFFFh to 0000h. On that wrap it sets a sticky overflow flag, which a clear input resets. The control register holds an oscillator-enable bit that is stored for readback and drives nothing. Two resets exist. The power-on reset clears everything. The soft reset clears all timer state but leaves the control register as it was.

Top module: `prescaled_timer16`

## Requirements
- R1: Register address 0 reads the control register with bits 7:6 always 0. Bits 5:0 read back exactly as written, including the oscillator-enable bit 3, which has no effect on counting. Address 3 reads 0.
- R2: After power-on reset, the control register, both counter bytes and the overflow flag are all 0.
- R3: A soft reset clears the counter and the overflow flag and keeps control bits 5:0 unchanged.
- R4: With bit 0 (run) = 1, bit 1 (source) = 0 and bits 5:4 = 00, the counter advances by 1 on every 4th system clock edge after the control write. After the write edge plus E further edges, the count equals floor(E/4).
- R5: Prescale field bits 5:4 = 00, 01, 10, 11 divides the source pulses by 1, 2, 4, 8. On the internal source the count after E edges is floor(E/(4·d)). On the external source every d-th edge counts.
- R6: With run bit 0 = 0, the counter holds its value on both sources.
- R7: With source = 1 and bit 2 (sync bypass) = 0, an input rising edge shows in the counter 3 clock edges after it is first sampled. With bit 2 = 1, it shows after 1 edge. Each rising edge counts once, however long the input stays high.
- R8: Bit 2 has no effect while the internal source is selected.
- R9: An increment from FFFFh gives 0000h and sets the overflow flag in the same edge. The flag stays set until the clear input is pulsed.
- R10: Address 1 writes the low byte and address 2 writes the high byte. A write to either byte, or to the control register, clears the prescaler count.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPor_n | input | 1 | Power-on reset, synchronous, active low |
| rstSoft_n | input | 1 | Soft reset, synchronous, active low, keeps control |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 low byte, 2 high byte |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational on regAddr |
| extClkIn | input | 1 | External count input |
| ovfClr | input | 1 | Clears the overflow flag |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A prescaler count that is not cleared on a write, or an internal phase that is out of step, shows as a count that is one step early or late. This becomes visible at the first prescaled tick after the write, which is at most 32 clocks later on the 1:8 setting. A corrupted synchronizer stage shows as a latency of one or three edges on the wrong mode, or as one input edge counted twice. Both appear within four clocks of the input edge. A lost overflow flag is visible on the flag output in the same edge as the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  // control field positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_SRC   = 1;
  localparam int BIT_NSYNC = 2;
  localparam int BIT_OSC   = 3;
  localparam int PS_LO     = 4;
  localparam int CTRL_W    = 6;

  typedef struct packed {
    logic incr;
    logic loadLo;
    logic loadHi;
    logic clrFlag;
  } tmrStrobeT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int QUARTER_W   = 2
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              rstSoft_n,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  input  logic              extClkIn,
  input  logic              ovfClr,
  output logic [CTRL_W-1:0] ctrlVal,
  output tmrStrobeT         strobe
);
  localparam int PIPE_W = SYNC_STAGES + 1;
  localparam logic [QUARTER_W-1:0] QTR_LAST = '1;

  logic [CTRL_W-1:0]    ctrlReg;
  logic [QUARTER_W-1:0] phase;
  logic [PIPE_W-1:0]    syncPipe;
  logic                 rawPrev;
  logic [PRE_W-1:0]     preCnt;
  logic [PRE_W-1:0]     psMask;
  logic ctrlWr, cntWr, rstAny_n;
  logic edgeSync, edgeRaw, srcPulse, preTick;

  assign rstAny_n = rstPor_n & rstSoft_n;
  assign ctrlWr   = regWr && (regAddr == ADDR_CTRL);
  assign cntWr    = regWr && (regAddr == ADDR_LO || regAddr == ADDR_HI);

  always_ff @(posedge clk) begin
    if (!rstPor_n)   ctrlReg <= '0;
    else if (ctrlWr) ctrlReg <= regWdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstAny_n || ctrlWr) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstAny_n) begin
      syncPipe <= '0;
      rawPrev  <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[PIPE_W-2:0], extClkIn};
      rawPrev  <= extClkIn;
    end
  end

  assign edgeSync = syncPipe[PIPE_W-2] & ~syncPipe[PIPE_W-1];
  assign edgeRaw  = extClkIn & ~rawPrev;

  always_comb begin
    srcPulse = 1'b0;
    if (ctrlReg[BIT_RUN]) begin
      if (ctrlReg[BIT_SRC]) srcPulse = ctrlReg[BIT_NSYNC] ? edgeRaw : edgeSync;
      else                  srcPulse = (phase == QTR_LAST);
    end
  end

  always_comb psMask = PRE_W'((4'd1 << ctrlReg[PS_LO +: 2]) - 4'd1);
  assign preTick = srcPulse && ((preCnt & psMask) == psMask);

  always_ff @(posedge clk) begin
    if (!rstAny_n || ctrlWr || cntWr) preCnt <= '0;
    else if (srcPulse)                preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.incr    = preTick && !cntWr;
    strobe.loadLo  = regWr && (regAddr == ADDR_LO);
    strobe.loadHi  = regWr && (regAddr == ADDR_HI);
    strobe.clrFlag = ovfClr;
  end

  assign ctrlVal = ctrlReg;

  // R6: a stopped timer never issues an increment
  p_no_incr_stopped_r6: assert property (@(posedge clk) disable iff (!rstAny_n)
    !ctrlReg[BIT_RUN] |-> !strobe.incr);
  // R10: any counter write empties the prescaler
  p_pre_clear_r10: assert property (@(posedge clk) disable iff (!rstAny_n)
    cntWr |=> (preCnt == '0));
  // R4: internal increments are never on back-to-back cycles
  p_int_spacing_r4: assert property (@(posedge clk) disable iff (!rstAny_n)
    (strobe.incr && !ctrlReg[BIT_SRC] && !ctrlWr) |=> !strobe.incr);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rstAny_n,
  input  tmrStrobeT           strobe,
  input  logic [HALF_W-1:0]   loadData,
  output logic [2*HALF_W-1:0] cntVal,
  output logic                ovfFlag
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic flag;
  logic anyLoad;

  assign anyLoad = strobe.loadLo | strobe.loadHi;

  always_ff @(posedge clk) begin
    if (!rstAny_n) begin
      cnt <= '0;
    end else if (strobe.loadLo) begin
      cnt[HALF_W-1:0] <= loadData;
    end else if (strobe.loadHi) begin
      cnt[CNT_W-1:HALF_W] <= loadData;
    end else if (strobe.incr) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstAny_n)                                  flag <= 1'b0;
    else if (strobe.incr && !anyLoad && cnt == CNT_MAX) flag <= 1'b1;
    else if (strobe.clrFlag)                        flag <= 1'b0;
  end

  assign cntVal  = cnt;
  assign ovfFlag = flag;

  // R4: one increment moves the count by exactly one
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstAny_n)
    (strobe.incr && !anyLoad) |=> (cnt == $past(cnt) + 1'b1));
  // R6: no increment and no load keeps the count
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstAny_n)
    (!strobe.incr && !anyLoad) |=> $stable(cnt));
  // R9: wrap raises the flag
  p_flag_on_wrap_r9: assert property (@(posedge clk) disable iff (!rstAny_n)
    (strobe.incr && !anyLoad && cnt == CNT_MAX) |=> (flag && cnt == '0));
  // R9: flag only rises on a wrap
  p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rstAny_n)
    $rose(flag) |-> ($past(cnt) == CNT_MAX));
endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstPor_n,
  input  logic       rstSoft_n,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       extClkIn,
  input  logic       ovfClr,
  output logic       ovfFlag
);
  localparam int HALF_W = 8;

  tmrStrobeT           strobe;
  logic [CTRL_W-1:0]   ctrlVal;
  logic [2*HALF_W-1:0] cntVal;

  tmr_ctrl #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES), .QUARTER_W(2)) ctrl_i (
    .clk(clk), .rstPor_n(rstPor_n), .rstSoft_n(rstSoft_n),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .extClkIn(extClkIn), .ovfClr(ovfClr),
    .ctrlVal(ctrlVal), .strobe(strobe)
  );

  tmr_count #(.HALF_W(HALF_W)) count_i (
    .clk(clk), .rstAny_n(rstPor_n & rstSoft_n),
    .strobe(strobe), .loadData(regWdata),
    .cntVal(cntVal), .ovfFlag(ovfFlag)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {{(8-CTRL_W){1'b0}}, ctrlVal};
      ADDR_LO:   regRdata = cntVal[HALF_W-1:0];
      ADDR_HI:   regRdata = cntVal[2*HALF_W-1:HALF_W];
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: tb/prescaled_timer16_tb.sv
module prescaled_timer16_tb_top;
  logic clk = 1'b0;
  logic rstPor_n = 1'b0, rstSoft_n = 1'b1;
  logic regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic extClkIn = 1'b0, ovfClr = 1'b0, ovfFlag;
  int nChecks = 0, nErrs = 0;

  always #4 clk = ~clk;

  prescaled_timer16 dut_i (
    .clk(clk), .rstPor_n(rstPor_n), .rstSoft_n(rstSoft_n),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .extClkIn(extClkIn),
    .ovfClr(ovfClr), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdCnt(output int v);
    regAddr = 2'd1; #1; v = regRdata;
    regAddr = 2'd2; #1; v = v | (int'(regRdata) << 8);
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCnt(input int v);
    wr(2'd0, 8'h00);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset_r2();
    int v;
    regAddr = 2'd0; #1; chk("R2 ctrl", regRdata, 0);
    rdCnt(v); chk("R2 cnt", v, 0);
    chk("R2 flag", ovfFlag, 0);
  endtask

  task automatic t_ctrl_r1();
    int v;
    wr(2'd0, 8'hC8);
    regAddr = 2'd0; #1; chk("R1 ctrl readback", regRdata, 8'h08);
    edges(20); rdCnt(v); chk("R1 osc bit no count", v, 0);
    regAddr = 2'd3; #1; chk("R1 addr3", regRdata, 0);
  endtask

  task automatic t_internal_r4_r8(input logic [7:0] c, input string tag);
    int v;
    loadCnt(0);
    wr(2'd0, c);
    edges(7); rdCnt(v); chk(tag, v, 1);
    edges(1); rdCnt(v); chk(tag, v, 2);
  endtask

  task automatic t_prescale_r5(input logic [1:0] ps);
    int v, d;
    d = 1 << ps;
    loadCnt(0);
    wr(2'd0, {2'b00, ps, 4'b0001});
    edges(8*d - 1); rdCnt(v); chk("R5 before tick", v, 1);
    edges(1); rdCnt(v); chk("R5 at tick", v, 2);
  endtask

  task automatic t_hold_r6();
    int v;
    loadCnt(5);
    wr(2'd0, 8'h30);
    edges(100); rdCnt(v); chk("R6 int hold", v, 5);
    wr(2'd0, 8'h06);
    repeat (3) begin extClkIn = 1; edges(3); extClkIn = 0; edges(3); end
    rdCnt(v); chk("R6 ext hold", v, 5);
  endtask

  task automatic t_ext_r7();
    int v;
    loadCnt(0);
    wr(2'd0, 8'h03);
    extClkIn = 1;
    edges(1); rdCnt(v); chk("R7 sync lat1", v, 0);
    edges(1); rdCnt(v); chk("R7 sync lat2", v, 0);
    edges(1); rdCnt(v); chk("R7 sync lat3", v, 1);
    edges(5); rdCnt(v); chk("R7 held high once", v, 1);
    extClkIn = 0; edges(4);
    repeat (3) begin extClkIn = 1; edges(3); extClkIn = 0; edges(3); end
    edges(3); rdCnt(v); chk("R7 sync count", v, 4);
    loadCnt(0);
    wr(2'd0, 8'h07);
    extClkIn = 1;
    edges(1); rdCnt(v); chk("R7 raw lat1", v, 1);
    extClkIn = 0; edges(3);
    loadCnt(0);
    wr(2'd0, 8'h13);
    repeat (4) begin extClkIn = 1; edges(3); extClkIn = 0; edges(3); end
    edges(3); rdCnt(v); chk("R5 ext div2", v, 2);
  endtask

  task automatic t_wrap_r9();
    int v;
    loadCnt(16'hFFFE);
    wr(2'd0, 8'h01);
    edges(7); rdCnt(v); chk("R9 at max", v, 16'hFFFF);
    chk("R9 flag low", ovfFlag, 0);
    edges(1); rdCnt(v); chk("R9 wrapped", v, 0);
    chk("R9 flag set", ovfFlag, 1);
    wr(2'd0, 8'h00);
    edges(10); chk("R9 sticky", ovfFlag, 1);
    ovfClr = 1; edges(1); ovfClr = 0;
    chk("R9 cleared", ovfFlag, 0);
  endtask

  task automatic t_load_r10();
    int v;
    loadCnt(16'h1234);
    rdCnt(v); chk("R10 load", v, 16'h1234);
    loadCnt(0);
    wr(2'd0, 8'h31);
    edges(24);
    wr(2'd1, 8'h00);
    edges(30); rdCnt(v); chk("R10 pre cleared", v, 0);
    edges(1); rdCnt(v); chk("R10 tick after clear", v, 1);
  endtask

  task automatic t_soft_r3();
    int v;
    wr(2'd0, 8'h00);
    loadCnt(16'h00AB);
    wr(2'd0, 8'h2C);
    rstSoft_n = 0; edges(1); rstSoft_n = 1;
    regAddr = 2'd0; #1; chk("R3 ctrl kept", regRdata, 8'h2C);
    rdCnt(v); chk("R3 cnt cleared", v, 0);
    rstPor_n = 0; edges(1); rstPor_n = 1;
    regAddr = 2'd0; #1; chk("R2 por ctrl", regRdata, 0);
  endtask

  initial begin
    edges(3);
    rstPor_n = 1'b1;
    t_reset_r2();
    edges(1);
    t_ctrl_r1();
    t_internal_r4_r8(8'h01, "R4 internal");
    t_internal_r4_r8(8'h05, "R8 sync bit ignored");
    for (int p = 1; p < 4; p++) t_prescale_r5(2'(p));
    t_hold_r6();
    t_ext_r7();
    t_wrap_r9();
    t_load_r10();
    t_soft_r3();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule